// File: doc/BRIEF.md
# Configuration-Space Window onto an APB Register Bus

This block places a vendor-specific extended capability in the extended configuration space of a PCIe function. The capability is four dwords long. Host software uses it as an indirect window onto a 32-bit APB register space. The first two dwords are the standard capability header and the vendor-specific header, and both are read-only. The third dword is a command register: it holds a target byte address and a direction flag. The fourth dword is a data register.

To write a register on the bus, software first loads the data register. It then writes the command register with the direction flag set, and that write starts the bus write using the data already held. To read a register, software writes the command register with the flag clear. It then reads the data register, which has received the bus read result by that time.

An address write that arrives while a bus transfer is still running is kept pending. It starts as soon as the running transfer finishes. The block answers every configuration read, including reads that fall outside its own dwords, so the PCIe core is never left waiting.

Top module: `pcie_apb_window`

## Requirements
- R1: The dword at configuration register number `CAP_BYTE_OFFSET/4` (0x120 by default) reads as {next pointer [31:20], version [19:16], capability ID [15:0]}. With the default parameters this is 0x0001000B.
- R2: The next dword reads as {capability length in bytes = 0x010 [31:20], revision [19:16], vendor ID [15:0]}. With the default parameters this is 0x010100DB.
- R3: Every configuration read strobe produces `cfgRdValid` high for exactly the one cycle after the strobe cycle, with data in that same cycle. A read of a register number outside the four capability dwords, or a read for any function number other than 0, returns zero.
- R4: A configuration write to the data dword (base+3) updates only the byte lanes whose byte enable is set. Bit i of the byte enables covers bits 8i+7:8i.
- R5: A configuration write to the command dword (base+2) stores bit 31 as the write flag and bits 15:0 as the bus byte address. All byte enables are ignored for this dword. A read of the command dword returns the flag in bit 31, the address in bits 15:0, and zero in all other bits.
- R6: Configuration writes to the two header dwords, and writes outside the capability or for a nonzero function, change nothing that can be read back.
- R7: A command write with bit 31 set starts a bus write to the stored address, using the data-register value held at start time. The transfer has one setup cycle (sel high, enable low), then access cycles with sel and enable high. During access, the address, direction and data stay stable until ready is sampled. The byte strobes are all ones throughout.
- R8: A command write with bit 31 clear starts a bus read with the same phases. The read data on the cycle ready is sampled is loaded into the data register.
- R9: A command write that arrives during a bus transfer is held until that transfer completes. It then starts, so the two transfers complete in the order they were requested.
- R10: After reset, sel and enable are low, read-valid is low, and the command and data registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgRdStrobe | input | 1 | Configuration read received |
| cfgWrStrobe | input | 1 | Configuration write received |
| cfgRegNum | input | 10 | Dword register number of the access |
| cfgFuncNum | input | 8 | Function number of the access |
| cfgWrData | input | 32 | Configuration write data |
| cfgByteEn | input | 4 | Configuration write byte enables |
| cfgRdData | output | 32 | Configuration read data |
| cfgRdValid | output | 1 | Configuration read data valid |
| apbAddr | output | 16 | Bus byte address |
| apbSel | output | 1 | Bus select |
| apbEnable | output | 1 | Bus enable (access phase) |
| apbWrite | output | 1 | Bus direction, 1 for write |
| apbWdata | output | 32 | Bus write data |
| apbStrb | output | 4 | Bus write byte strobes |
| apbRdata | input | 32 | Bus read data |
| apbReady | input | 1 | Bus ready |

## Verification
The bench builds the block with its default parameters, so the capability sits at dword 0x120 and the bus address is 16 bits wide. These defaults make the header values, the range boundaries on both sides of the window, and the function-number filter directly checkable.

The bus responder in the bench has a wait-state count that the test can set. This lets it hold the access phase for several cycles, so that a second command write can be issued into a transfer that is still running. A reference model of the handshake phases and the read-valid pulse is compared with the outputs on every clock.

// File: rtl/pcie_apb_win_pkg.sv
package pcie_apb_win_pkg;

  localparam int CFG_W      = 32;
  localparam int CFG_BYTES  = CFG_W / 8;
  localparam int SLOT_COUNT = 4;
  localparam int SLOT_SEL_W = $clog2(SLOT_COUNT);

  typedef enum logic [SLOT_SEL_W-1:0] {
    SLOT_HDR0 = 2'd0,
    SLOT_HDR1 = 2'd1,
    SLOT_CMD  = 2'd2,
    SLOT_DATA = 2'd3
  } winSlot_t;

  typedef enum logic [1:0] {
    BUS_IDLE   = 2'd0,
    BUS_SETUP  = 2'd1,
    BUS_ACCESS = 2'd2
  } busPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     rdFire;
    logic     rdHit;
    winSlot_t slot;
    logic     wrCmd;
    logic     wrData;
    logic     launch;
    logic     complete;
  } winStrobe_t;

endpackage

// File: rtl/pcie_apb_win_ctrl.sv
module pcie_apb_win_ctrl
  import pcie_apb_win_pkg::*;
#(
  parameter logic [11:0] CAP_BYTE_OFFSET = 12'h480,
  parameter int          REGNUM_W        = 10,
  parameter int          FUNC_W          = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgRdStrobe,
  input  logic                cfgWrStrobe,
  input  logic [REGNUM_W-1:0] cfgRegNum,
  input  logic [FUNC_W-1:0]   cfgFuncNum,
  input  logic                apbReady,
  output winStrobe_t          strb,
  output logic                busSel,
  output logic                busEnable
);

  localparam int unsigned         BASE_DW  = int'(CAP_BYTE_OFFSET) >> 2;
  localparam logic [REGNUM_W-1:0] BASE_IDX = REGNUM_W'(BASE_DW);
  localparam logic [REGNUM_W-1:0] SPAN     = REGNUM_W'(SLOT_COUNT);

  logic [REGNUM_W-1:0] relIdx;
  logic                inRange;
  winSlot_t            slot;
  busPhase_t           phase, phaseNext;
  logic                pending;
  logic                launch, complete;

  // unsigned wrap makes numbers below the base fall out of range
  always_comb begin
    relIdx  = cfgRegNum - BASE_IDX;
    inRange = (cfgFuncNum == '0) && (relIdx < SPAN);
    slot    = winSlot_t'(relIdx[SLOT_SEL_W-1:0]);
  end

  always_comb begin
    launch   = (phase == BUS_IDLE) && pending;
    complete = (phase == BUS_ACCESS) && apbReady;
    phaseNext = phase;
    case (phase)
      BUS_IDLE:   if (pending) phaseNext = BUS_SETUP;
      BUS_SETUP:  phaseNext = BUS_ACCESS;
      BUS_ACCESS: if (apbReady) phaseNext = BUS_IDLE;
      default:    phaseNext = BUS_IDLE;
    endcase
  end

  always_comb begin
    strb.rdFire   = cfgRdStrobe;
    strb.rdHit    = inRange;
    strb.slot     = slot;
    strb.wrCmd    = cfgWrStrobe && inRange && (slot == SLOT_CMD);
    strb.wrData   = cfgWrStrobe && inRange && (slot == SLOT_DATA);
    strb.launch   = launch;
    strb.complete = complete;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= BUS_IDLE;
      pending <= 1'b0;
    end else begin
      phase   <= phaseNext;
      // a command arriving on the launch edge stays pending for the next slot
      pending <= (pending && !launch) || strb.wrCmd;
    end
  end

  assign busSel    = (phase != BUS_IDLE);
  assign busEnable = (phase == BUS_ACCESS);

endmodule

// File: rtl/pcie_apb_win_dp.sv
module pcie_apb_win_dp
  import pcie_apb_win_pkg::*;
#(
  parameter logic [15:0] CAP_ID      = 16'h000B,
  parameter logic [3:0]  CAP_VER     = 4'h1,
  parameter logic [11:0] CAP_NEXT    = 12'h000,
  parameter logic [15:0] VSEC_VENDOR = 16'h00DB,
  parameter logic [3:0]  VSEC_REV    = 4'h1,
  parameter int          APB_ADDR_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  winStrobe_t            strb,
  input  logic [CFG_W-1:0]      cfgWrData,
  input  logic [CFG_BYTES-1:0]  cfgByteEn,
  input  logic [CFG_W-1:0]      apbRdata,
  output logic [CFG_W-1:0]      cfgRdData,
  output logic                  cfgRdValid,
  output logic [APB_ADDR_W-1:0] busAddr,
  output logic                  busWrite,
  output logic [CFG_W-1:0]      busWdata
);

  localparam logic [11:0]  VSEC_LEN  = 12'(SLOT_COUNT * 4);
  localparam logic [CFG_W-1:0] HDR0_WORD = {CAP_NEXT, CAP_VER, CAP_ID};
  localparam logic [CFG_W-1:0] HDR1_WORD = {VSEC_LEN, VSEC_REV, VSEC_VENDOR};
  localparam int PAD_W = CFG_W - 1 - APB_ADDR_W;

  logic                  cmdFlag;
  logic [APB_ADDR_W-1:0] cmdAddr;
  logic [CFG_W-1:0]      dataWord;
  logic [CFG_W-1:0]      readMux;

  // data register, one lane per byte enable
  for (genvar ln = 0; ln < CFG_BYTES; ln++) begin : g_lane
    logic [7:0] laneQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        laneQ <= '0;
      end else if (strb.wrData && cfgByteEn[ln]) begin
        laneQ <= cfgWrData[ln*8 +: 8];
      end else if (strb.complete && !busWrite) begin
        laneQ <= apbRdata[ln*8 +: 8];
      end
    end
    assign dataWord[ln*8 +: 8] = laneQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdFlag <= 1'b0;
      cmdAddr <= '0;
    end else if (strb.wrCmd) begin
      cmdFlag <= cfgWrData[CFG_W-1];
      cmdAddr <= cfgWrData[APB_ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busAddr  <= '0;
      busWrite <= 1'b0;
      busWdata <= '0;
    end else if (strb.launch) begin
      busAddr  <= cmdAddr;
      busWrite <= cmdFlag;
      busWdata <= dataWord;
    end
  end

  always_comb begin
    case (strb.slot)
      SLOT_HDR0: readMux = HDR0_WORD;
      SLOT_HDR1: readMux = HDR1_WORD;
      SLOT_CMD:  readMux = {cmdFlag, {PAD_W{1'b0}}, cmdAddr};
      default:   readMux = dataWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgRdValid <= 1'b0;
      cfgRdData  <= '0;
    end else begin
      cfgRdValid <= strb.rdFire;
      cfgRdData  <= (strb.rdFire && strb.rdHit) ? readMux : '0;
    end
  end

endmodule

// File: rtl/pcie_apb_window.sv
module pcie_apb_window
  import pcie_apb_win_pkg::*;
#(
  parameter logic [11:0] CAP_BYTE_OFFSET = 12'h480,
  parameter logic [15:0] CAP_ID          = 16'h000B,
  parameter logic [3:0]  CAP_VER         = 4'h1,
  parameter logic [11:0] CAP_NEXT        = 12'h000,
  parameter logic [15:0] VSEC_VENDOR     = 16'h00DB,
  parameter logic [3:0]  VSEC_REV        = 4'h1,
  parameter int          REGNUM_W        = 10,
  parameter int          FUNC_W          = 8,
  parameter int          APB_ADDR_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfgRdStrobe,
  input  logic                  cfgWrStrobe,
  input  logic [REGNUM_W-1:0]   cfgRegNum,
  input  logic [FUNC_W-1:0]     cfgFuncNum,
  input  logic [31:0]           cfgWrData,
  input  logic [3:0]            cfgByteEn,
  output logic [31:0]           cfgRdData,
  output logic                  cfgRdValid,
  output logic [APB_ADDR_W-1:0] apbAddr,
  output logic                  apbSel,
  output logic                  apbEnable,
  output logic                  apbWrite,
  output logic [31:0]           apbWdata,
  output logic [3:0]            apbStrb,
  input  logic [31:0]           apbRdata,
  input  logic                  apbReady
);

  winStrobe_t strb;

  pcie_apb_win_ctrl #(
    .CAP_BYTE_OFFSET(CAP_BYTE_OFFSET),
    .REGNUM_W       (REGNUM_W),
    .FUNC_W         (FUNC_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfgRdStrobe(cfgRdStrobe),
    .cfgWrStrobe(cfgWrStrobe),
    .cfgRegNum  (cfgRegNum),
    .cfgFuncNum (cfgFuncNum),
    .apbReady   (apbReady),
    .strb       (strb),
    .busSel     (apbSel),
    .busEnable  (apbEnable)
  );

  pcie_apb_win_dp #(
    .CAP_ID     (CAP_ID),
    .CAP_VER    (CAP_VER),
    .CAP_NEXT   (CAP_NEXT),
    .VSEC_VENDOR(VSEC_VENDOR),
    .VSEC_REV   (VSEC_REV),
    .APB_ADDR_W (APB_ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .cfgWrData (cfgWrData),
    .cfgByteEn (cfgByteEn),
    .apbRdata  (apbRdata),
    .cfgRdData (cfgRdData),
    .cfgRdValid(cfgRdValid),
    .busAddr   (apbAddr),
    .busWrite  (apbWrite),
    .busWdata  (apbWdata)
  );

  assign apbStrb = '1;

endmodule

// File: rtl/pcie_apb_win_chk.sv
module pcie_apb_win_chk #(
  parameter int REGNUM_W   = 10,
  parameter int FUNC_W     = 8,
  parameter int APB_ADDR_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfgRdStrobe,
  input logic [FUNC_W-1:0]     cfgFuncNum,
  input logic [31:0]           cfgRdData,
  input logic                  cfgRdValid,
  input logic [APB_ADDR_W-1:0] apbAddr,
  input logic                  apbSel,
  input logic                  apbEnable,
  input logic                  apbWrite,
  input logic [31:0]           apbWdata,
  input logic [3:0]            apbStrb,
  input logic                  apbReady
);

  // R7
  enable_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    apbEnable |-> apbSel);

  // R7
  setup_then_access_chk: assert property (@(posedge clk) disable iff (rst)
    (apbSel && !apbEnable) |=> (apbSel && apbEnable));

  // R7
  access_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (apbEnable && !apbReady) |=> (apbEnable && $stable(apbAddr) &&
                                  $stable(apbWrite) && $stable(apbWdata)));

  // R7
  strobe_full_chk: assert property (@(posedge clk) disable iff (rst)
    apbSel |-> (apbStrb == 4'hF));

  // R8
  done_returns_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (apbEnable && apbReady) |=> !apbEnable);

  // R3
  read_answered_chk: assert property (@(posedge clk) disable iff (rst)
    cfgRdStrobe |=> cfgRdValid);

  // R3
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !cfgRdStrobe |=> !cfgRdValid);

  // R3
  other_func_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfgRdStrobe && (cfgFuncNum != '0)) |=> (cfgRdData == '0));

endmodule

bind pcie_apb_window pcie_apb_win_chk #(
  .REGNUM_W  (REGNUM_W),
  .FUNC_W    (FUNC_W),
  .APB_ADDR_W(APB_ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfgRdStrobe(cfgRdStrobe),
  .cfgFuncNum (cfgFuncNum),
  .cfgRdData  (cfgRdData),
  .cfgRdValid (cfgRdValid),
  .apbAddr    (apbAddr),
  .apbSel     (apbSel),
  .apbEnable  (apbEnable),
  .apbWrite   (apbWrite),
  .apbWdata   (apbWdata),
  .apbStrb    (apbStrb),
  .apbReady   (apbReady)
);

// File: tb/sim_pcie_apb_window.sv
module sim_pcie_apb_window;

  localparam logic [9:0] BASE = 10'h120;
  localparam logic [9:0] R_HDR0 = BASE;
  localparam logic [9:0] R_HDR1 = BASE + 10'd1;
  localparam logic [9:0] R_CMD  = BASE + 10'd2;
  localparam logic [9:0] R_DATA = BASE + 10'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgRdStrobe = 1'b0;
  logic        cfgWrStrobe = 1'b0;
  logic [9:0]  cfgRegNum = '0;
  logic [7:0]  cfgFuncNum = '0;
  logic [31:0] cfgWrData = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgRdData;
  logic        cfgRdValid;
  logic [15:0] apbAddr;
  logic        apbSel, apbEnable, apbWrite;
  logic [31:0] apbWdata;
  logic [3:0]  apbStrb;
  logic [31:0] apbRdata = '0;
  logic        apbReady = 1'b0;

  int checks = 0;
  int fails = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pcie_apb_window u0 (
    .clk(clk), .rst(rst),
    .cfgRdStrobe(cfgRdStrobe), .cfgWrStrobe(cfgWrStrobe),
    .cfgRegNum(cfgRegNum), .cfgFuncNum(cfgFuncNum),
    .cfgWrData(cfgWrData), .cfgByteEn(cfgByteEn),
    .cfgRdData(cfgRdData), .cfgRdValid(cfgRdValid),
    .apbAddr(apbAddr), .apbSel(apbSel), .apbEnable(apbEnable),
    .apbWrite(apbWrite), .apbWdata(apbWdata), .apbStrb(apbStrb),
    .apbRdata(apbRdata), .apbReady(apbReady)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  // bus responder with programmable wait states
  int          waitN = 0;
  int          waitCnt = 0;
  logic [31:0] mem [16];
  logic [15:0] wrLog [$];
  logic [3:0]  lastStrb = '0;

  always @(negedge clk) begin
    apbReady = 1'b0;
    if (apbSel && apbEnable) begin
      if (waitCnt >= waitN) begin
        apbReady = 1'b1;
        waitCnt = 0;
        if (apbWrite) begin
          mem[apbAddr[5:2]] = apbWdata;
          wrLog.push_back(apbAddr);
          lastStrb = apbStrb;
        end else begin
          apbRdata = mem[apbAddr[5:2]];
        end
      end else begin
        waitCnt++;
      end
    end
  end

  // behavioural reference: bus phase (0 idle, 1 setup, 2 access), pending request, read-valid
  int mPh = 0;
  bit mPend = 1'b0;
  bit mValid = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      mPh = 0; mPend = 1'b0; mValid = 1'b0;
    end else begin
      mValid = cfgRdStrobe;
      if (mPh == 2) begin
        if (apbReady) mPh = 0;
      end else if (mPh == 1) begin
        mPh = 2;
      end else if (mPend) begin
        mPh = 1; mPend = 1'b0;
      end
      if (cfgWrStrobe && cfgFuncNum == 8'd0 && cfgRegNum == R_CMD) mPend = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (running && !rst) begin
      chk(cfgRdValid == mValid, "R3 valid pulse", 32'(cfgRdValid), 32'(mValid));
      chk(apbSel == (mPh != 0), "R7 sel phase", 32'(apbSel), 32'(mPh != 0));
      chk(apbEnable == (mPh == 2), "R9 enable phase", 32'(apbEnable), 32'(mPh == 2));
    end
  end

  task automatic cfgWrite(input logic [9:0] r, input logic [7:0] f, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfgWrStrobe = 1'b1; cfgRegNum = r; cfgFuncNum = f; cfgWrData = d; cfgByteEn = be;
    @(negedge clk);
    cfgWrStrobe = 1'b0; cfgByteEn = '0;
  endtask

  task automatic cfgRead(input logic [9:0] r, input logic [7:0] f, output logic [31:0] d);
    @(negedge clk);
    cfgRdStrobe = 1'b1; cfgRegNum = r; cfgFuncNum = f;
    @(negedge clk);
    cfgRdStrobe = 1'b0;
    d = cfgRdData;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + 32'(i);
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!apbSel && !apbEnable, "R10 bus idle in reset", {apbSel, apbEnable}, 0);
    chk(!cfgRdValid, "R10 valid low in reset", 32'(cfgRdValid), 0);
    rst = 1'b0;
    running = 1'b1;
    cfgRead(R_CMD, 8'd0, d);  chk(d == 32'h0, "R10 cmd cleared", d, 32'h0);
    cfgRead(R_DATA, 8'd0, d); chk(d == 32'h0, "R10 data cleared", d, 32'h0);

    // R1 / R2 headers
    cfgRead(R_HDR0, 8'd0, d); chk(d == 32'h0001000B, "R1 capability header", d, 32'h0001000B);
    cfgRead(R_HDR1, 8'd0, d); chk(d == 32'h010100DB, "R2 vendor header", d, 32'h010100DB);

    // R3 out-of-range and other function
    cfgRead(BASE + 10'd4, 8'd0, d); chk(d == 0, "R3 above range", d, 0);
    cfgRead(BASE - 10'd1, 8'd0, d); chk(d == 0, "R3 below range", d, 0);
    cfgRead(R_HDR0, 8'd1, d);       chk(d == 0, "R3 other function", d, 0);

    // R4 byte enables
    cfgWrite(R_DATA, 8'd0, 32'h11223344, 4'hF);
    cfgWrite(R_DATA, 8'd0, 32'hAABBCCDD, 4'b0101);
    cfgRead(R_DATA, 8'd0, d); chk(d == 32'h11BB33DD, "R4 byte lanes", d, 32'h11BB33DD);

    // R6 ignored writes
    cfgWrite(R_HDR0, 8'd0, 32'hFFFFFFFF, 4'hF);
    cfgWrite(R_HDR1, 8'd0, 32'h0, 4'hF);
    cfgWrite(R_DATA, 8'd1, 32'hDEADDEAD, 4'hF);
    cfgWrite(BASE + 10'd4, 8'd0, 32'hDEADDEAD, 4'hF);
    cfgRead(R_HDR0, 8'd0, d); chk(d == 32'h0001000B, "R6 hdr0 unchanged", d, 32'h0001000B);
    cfgRead(R_HDR1, 8'd0, d); chk(d == 32'h010100DB, "R6 hdr1 unchanged", d, 32'h010100DB);
    cfgRead(R_DATA, 8'd0, d); chk(d == 32'h11BB33DD, "R6 data unchanged", d, 32'h11BB33DD);
    cfgRead(R_CMD, 8'd0, d);  chk(d == 32'h0, "R6 cmd unchanged", d, 32'h0);

    // R7 write launch with waits, R5 command readback
    waitN = 2;
    cfgWrite(R_DATA, 8'd0, 32'hCAFEF00D, 4'hF);
    cfgWrite(R_CMD, 8'd0, 32'hFFFF0010, 4'h0);
    repeat (12) @(negedge clk);
    chk(mem[4] == 32'hCAFEF00D, "R7 bus write data", mem[4], 32'hCAFEF00D);
    chk(wrLog.size() == 1 && wrLog[0] == 16'h0010, "R7 bus write address",
        wrLog.size() > 0 ? 32'(wrLog[0]) : 32'hFFFFFFFF, 32'h10);
    chk(lastStrb == 4'hF, "R7 strobes", 32'(lastStrb), 32'hF);
    cfgRead(R_CMD, 8'd0, d); chk(d == 32'h80000010, "R5 cmd readback", d, 32'h80000010);

    // R8 read launch
    waitN = 3;
    mem[7] = 32'h5A5A1234;
    cfgWrite(R_CMD, 8'd0, 32'h0000001C, 4'hF);
    repeat (12) @(negedge clk);
    cfgRead(R_DATA, 8'd0, d); chk(d == 32'h5A5A1234, "R8 read result", d, 32'h5A5A1234);
    cfgRead(R_CMD, 8'd0, d);  chk(d == 32'h0000001C, "R5 read cmd readback", d, 32'h1C);
    chk(wrLog.size() == 1, "R8 read made no write", 32'(wrLog.size()), 1);

    // R9 command during transfer
    waitN = 5;
    cfgWrite(R_DATA, 8'd0, 32'h0BADBEEF, 4'hF);
    cfgWrite(R_CMD, 8'd0, 32'h80000020, 4'hF);
    cfgWrite(R_DATA, 8'd0, 32'h600DCAFE, 4'hF);
    chk(apbSel, "R9 first transfer in flight", 32'(apbSel), 1);
    cfgWrite(R_CMD, 8'd0, 32'h80000024, 4'hF);
    repeat (30) @(negedge clk);
    chk(mem[8] == 32'h0BADBEEF, "R9 first data", mem[8], 32'h0BADBEEF);
    chk(mem[9] == 32'h600DCAFE, "R9 held second data", mem[9], 32'h600DCAFE);
    chk(wrLog.size() == 3 && wrLog[1] == 16'h20 && wrLog[2] == 16'h24, "R9 order",
        32'(wrLog.size()), 3);

    // R3 back-to-back reads: valid per strobe
    @(negedge clk); cfgRdStrobe = 1'b1; cfgRegNum = R_HDR0; cfgFuncNum = 8'd0;
    @(negedge clk); cfgRegNum = R_HDR1;
    chk(cfgRdValid && cfgRdData == 32'h0001000B, "R3 first of pair", cfgRdData, 32'h0001000B);
    @(negedge clk); cfgRdStrobe = 1'b0;
    chk(cfgRdValid && cfgRdData == 32'h010100DB, "R3 second of pair", cfgRdData, 32'h010100DB);
    @(negedge clk);
    chk(!cfgRdValid, "R3 valid drops", 32'(cfgRdValid), 0);

    repeat (4) @(negedge clk);
    running = 1'b0;
    finish_run();
  end

endmodule